// File: doc/BRIEF.md
# Scaled Comfort Noise Injector

This block sits at the output of an echo-suppression path. On each sample strobe it either forwards the residual sample unchanged or puts synthetic comfort noise in its place. It substitutes noise only when three conditions hold: the nonlinear suppressor is switched on, the injector is not disabled, and the magnitude of the residual falls below a programmable threshold.

The noise source is a pseudo-random sequence. Its amplitude follows a background-noise level estimate supplied from outside the block. A linear 8-bit trim then adjusts that amplitude, and the code 0x80 gives unity gain.

The threshold is a Q15 fraction of a reference level that is fixed by a parameter. Noise estimation, spectral shaping and register access are handled elsewhere in the chip. All of them reach this block as plain inputs.

Top module: `cn_injector`

## Requirements
- R1: While `rst` is high, `smp_out` becomes 0 at the next clock edge and the noise generator is loaded with the nonzero seed 23'h2B3C4D.
- R2: `smp_out` changes only on the clock edge that samples `smp_valid` high, so the new value appears one clock after the strobe. In every other cycle it holds its value.
- R3: Suppression is active when `nlp_en` is 1, `inj_off` is 0 and |`resid_in`| < (`nlp_thr` × REF_LVL) >> 15. `nlp_thr` is an unsigned Q15 fraction and REF_LVL defaults to 16384. A magnitude equal to this limit is not suppressed, and |−32768| is taken as 32768.
- R4: When `inj_off` is 1, a strobed `resid_in` passes to `smp_out` unchanged.
- R5: When `nlp_en` is 0, a strobed `resid_in` passes to `smp_out` unchanged, whatever the value of `nlp_thr`.
- R6: While suppressing, the raw noise n is bits [22:7] of the generator state, read as signed. The base amplitude is a = floor(n × `bg_level` / 2^15), with `bg_level` unsigned.
- R7: The injected value is floor(a × `nz_scale` / 128). This is linear in the code: 0x80 gives exactly a, and 0x5B gives about 3 dB less.
- R8: The injected value saturates to the range −32768 to 32767.
- R9: The generator advances on every strobe, whether or not the sample is suppressed. The step is s ← {s[21:0], s[22] ^ s[17]}, and the state used for a sample is the one held before that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| resid_in | input | 16 | Signed residual sample |
| bg_level | input | 16 | Unsigned Q15 background-noise level |
| nlp_en | input | 1 | Nonlinear suppressor enable |
| inj_off | input | 1 | 1 disables noise injection |
| nlp_thr | input | 16 | Q15 suppression threshold fraction |
| nz_scale | input | 8 | Linear noise trim, 0x80 = unity |
| smp_out | output | 16 | Selected signed output sample |

## Verification
One strobe does two things at once: it makes the suppress-or-pass decision and it advances the noise generator. The bench therefore places pass-through strobes (suppressor off, injector disabled, or magnitude exactly at the limit) between suppressed strobes. A generator that stalls on pass-through samples then produces a noise value that differs from the behavioural model. In the same way, large level and scale codes push saturation into the same cycle as a threshold-boundary decision, and the registered output is compared against the model on every clock.

// File: rtl/cn_pkg.sv
package cn_pkg;
  localparam int SAMPLE_W = 16;

  function automatic logic signed [15:0] sat16(input logic signed [19:0] v);
    if (v > 20'sd32767)       return 16'sh7FFF;
    else if (v < -20'sd32768) return 16'sh8000;
    else                      return v[15:0];
  endfunction
endpackage

// File: rtl/cn_lfsr.sv
module cn_lfsr #(
  parameter int              LEN  = 23,
  parameter int              TAP  = 18,
  parameter logic [LEN-1:0]  SEED = 23'h2B3C4D
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  output logic [LEN-1:0] state
);
  logic fb;
  assign fb = state[LEN-1] ^ state[TAP-1];

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= {state[LEN-2:0], fb};
  end
endmodule

// File: rtl/cn_gate.sv
module cn_gate #(
  parameter int W       = 16,
  parameter int REF_LVL = 16384
) (
  input  logic [W-1:0] resid,
  input  logic [W-1:0] thr,
  input  logic         nlp_en,
  input  logic         inj_off,
  output logic         suppress
);
  localparam int PW = 2*W + 1;
  localparam logic [PW-1:0] REF_C = PW'(REF_LVL);

  logic [W:0]    mag;
  logic [PW-1:0] lprod;
  logic [W:0]    limit;

  always_comb begin
    if (resid[W-1]) mag = (W+1)'(~{resid[W-1], resid} + (W+1)'(1));
    else            mag = {1'b0, resid};
  end

  assign lprod    = PW'(thr) * REF_C;
  assign limit    = lprod[2*W-1:W-1];
  assign suppress = nlp_en && !inj_off && (mag < limit);
endmodule

// File: rtl/cn_gain.sv
module cn_gain #(
  parameter int W  = 16,
  parameter int SW = 8
) (
  input  logic signed [W-1:0] raw,
  input  logic        [W-1:0] level,
  input  logic        [SW-1:0] scale,
  output logic signed [W-1:0] noise
);
  localparam int P1W = 2*W + 1;
  localparam int AW  = W + 2;
  localparam int P2W = AW + SW + 1;
  localparam int BW  = P2W - 7;

  logic signed [P1W-1:0] p1;
  logic signed [AW-1:0]  amp;
  logic signed [P2W-1:0] p2;
  logic signed [BW-1:0]  trimmed;

  assign p1      = P1W'(raw) * $signed({1'b0, level});
  assign amp     = p1[P1W-1:W-1];
  assign p2      = P2W'(amp) * $signed({1'b0, scale});
  assign trimmed = p2[P2W-1:7];
  assign noise   = cn_pkg::sat16(20'(trimmed));
endmodule

// File: rtl/cn_injector.sv
module cn_injector #(
  parameter int             REF_LVL = 16384,
  parameter logic [22:0]    SEED    = 23'h2B3C4D
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        smp_valid,
  input  logic [15:0] resid_in,
  input  logic [15:0] bg_level,
  input  logic        nlp_en,
  input  logic        inj_off,
  input  logic [15:0] nlp_thr,
  input  logic [7:0]  nz_scale,
  output logic [15:0] smp_out
);
  localparam int W  = cn_pkg::SAMPLE_W;
  localparam int LN = 23;

  logic [LN-1:0] lfsr_q;
  logic          supp;
  logic [W-1:0]  noise_s;

  cn_lfsr #(.LEN(LN), .TAP(18), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step(smp_valid), .state(lfsr_q)
  );

  cn_gate #(.W(W), .REF_LVL(REF_LVL)) u_gate (
    .resid(resid_in), .thr(nlp_thr), .nlp_en(nlp_en),
    .inj_off(inj_off), .suppress(supp)
  );

  cn_gain #(.W(W), .SW(8)) u_gain (
    .raw(lfsr_q[LN-1:LN-W]), .level(bg_level), .scale(nz_scale), .noise(noise_s)
  );

  always_ff @(posedge clk) begin
    if (rst)            smp_out <= '0;
    else if (smp_valid) smp_out <= supp ? noise_s : resid_in;
  end
endmodule

// File: rtl/cn_injector_chk.sv
module cn_injector_chk (
  input logic        clk,
  input logic        rst,
  input logic        smp_valid,
  input logic [15:0] resid_in,
  input logic [15:0] bg_level,
  input logic        nlp_en,
  input logic        inj_off,
  input logic [22:0] lfsr_q,
  input logic [15:0] smp_out
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (smp_out == 16'h0));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(smp_out));
  p_pass_off_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && inj_off) |=> (smp_out == $past(resid_in)));
  p_pass_nlp_r5: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !nlp_en) |=> (smp_out == $past(resid_in)));
  p_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && bg_level == 16'h0) |=> (smp_out == 16'h0 || smp_out == $past(resid_in)));
  p_gen_live_r9: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != 23'h0);
  p_gen_step_r9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(lfsr_q));
endmodule

bind cn_injector cn_injector_chk u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .resid_in(resid_in),
  .bg_level(bg_level), .nlp_en(nlp_en), .inj_off(inj_off),
  .lfsr_q(lfsr_q), .smp_out(smp_out)
);

// File: tb/cn_injector_tb.sv
`timescale 1ns/1ps
module cn_injector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] resid_in = '0;
  logic [15:0] bg_level = '0;
  logic        nlp_en = 1'b0;
  logic        inj_off = 1'b0;
  logic [15:0] nlp_thr = '0;
  logic [7:0]  nz_scale = 8'h80;
  logic [15:0] smp_out;

  always #4 clk = ~clk;

  cn_injector u_dut (.*);

  int  n_run = 0, n_fail = 0;
  int  m_lfsr;
  int  m_exp;
  bit  done = 0;

  function automatic int ref_noise(int st, int lvl, int sc);
    longint raw, a, b;
    raw = (st >> 7) & 16'hFFFF;
    if (raw >= 32768) raw -= 65536;
    a = (raw * lvl) >>> 15;
    b = (a * sc) >>> 7;
    if (b > 32767) b = 32767;
    if (b < -32768) b = -32768;
    return int'(b) & 16'hFFFF;
  endfunction

  function automatic int mag_of(logic [15:0] v);
    int s;
    s = $signed(v);
    return (s < 0) ? -s : s;
  endfunction

  task automatic tick(string req);
    @(posedge clk);
    #1;
    if (rst) begin
      m_exp = 0;
      m_lfsr = 23'h2B3C4D;
    end else if (smp_valid) begin
      if (nlp_en && !inj_off && mag_of(resid_in) < ((int'(nlp_thr) * 16384) >> 15))
        m_exp = ref_noise(m_lfsr, bg_level, nz_scale);
      else
        m_exp = resid_in;
      m_lfsr = ((m_lfsr << 1) & 23'h7FFFFF) | (((m_lfsr >> 22) ^ (m_lfsr >> 17)) & 1);
    end
    @(negedge clk);
    n_run++;
    if (smp_out !== 16'(m_exp)) begin
      n_fail++;
      $display("FAIL %s: smp_out=%h expected=%h", req, smp_out, 16'(m_exp));
    end
  endtask

  task automatic strobe(string req, logic [15:0] r);
    resid_in = r; smp_valid = 1'b1;
    tick(req);
    smp_valid = 1'b0;
  endtask

  initial begin
    m_lfsr = 23'h2B3C4D; m_exp = 0;
    @(negedge clk);
    tick("R1");
    tick("R1");
    rst = 1'b0;
    tick("R1");
    // R5: suppressor off, small residual passes
    nlp_en = 0; nlp_thr = 16'h7FFF; bg_level = 16'h4000;
    strobe("R5", 16'h0010);
    strobe("R5", 16'hFFF0);
    // R2: no strobe, output holds
    resid_in = 16'h1234;
    tick("R2"); tick("R2");
    // R3/R6: suppression with unity trim
    nlp_en = 1; nz_scale = 8'h80;
    for (int i = 0; i < 8; i++) strobe("R6", 16'(i * 3 - 10));
    // R4: injector disabled, passes (generator keeps moving, R9)
    inj_off = 1;
    strobe("R4", 16'h0005);
    strobe("R4", 16'h0000);
    inj_off = 0;
    strobe("R9", 16'h0001);
    // R3: boundary, limit = 0x1000 with thr 0x2000
    nlp_thr = 16'h2000;
    strobe("R3", 16'h1000);
    strobe("R3", 16'h0FFF);
    strobe("R3", 16'hF000);
    strobe("R3", 16'hF001);
    strobe("R3", 16'h8000);
    // R7: linear trim
    nlp_thr = 16'h7FFF;
    nz_scale = 8'h5B;
    for (int i = 0; i < 6; i++) strobe("R7", 16'h0002);
    nz_scale = 8'h40;
    for (int i = 0; i < 4; i++) strobe("R7", 16'h0002);
    nz_scale = 8'h00;
    strobe("R7", 16'h0002);
    // R8: saturation with maximal level and trim
    bg_level = 16'hFFFF; nz_scale = 8'hFF;
    for (int i = 0; i < 16; i++) strobe("R8", 16'h0003);
    // R9: mixed pass / suppress sequence
    for (int i = 0; i < 30; i++) begin
      nlp_en = (i % 3) != 0;
      bg_level = 16'(i * 2111);
      nz_scale = 8'(i * 37);
      strobe("R9", 16'(i * 523));
      if (i % 4 == 0) tick("R2");
    end
    // R1: reset mid-run
    rst = 1'b1;
    tick("R1");
    rst = 1'b0;
    nlp_en = 1; bg_level = 16'h4000; nz_scale = 8'h80;
    strobe("R1", 16'h0000);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule